// File: doc/BRIEF.md
# Packed Two-Entry Colour Lookup Memory

This block stores a 256-colour lookup table for a display pipeline. A register-style bus port sees the table as 128 word locations. Each 32-bit word carries two 16-bit colour codes. The low half holds the even entry and the high half holds the odd entry that follows it. Each code has three 5-bit components and one spare intensity flag.

When the bus writes a word, the block keeps that word exactly as written so that software can read it back. The block also writes the two matching entries of a separate expanded table. Each entry in that table holds 24-bit colour, with every component widened to 8 bits.

The pixel side presents an 8-bit index and gets the expanded colour from a register one clock later. This keeps the lookup path free of any bus decode logic.

Top module: `palette_ram`

## Requirements
- R1: After reset, every readable table word returns zero, and the pixel output is zero for any index.
- R2: A bus read of a byte address in 0x200..0x3FF returns the full 32-bit word last written to that word location, including both intensity flags.
- R3: Word location n (byte address 0x200 + 4n) defines entry 2n from data bits 15:0 and entry 2n+1 from data bits 31:16.
- R4: Within a 16-bit code, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. The pixel output places red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each output byte is the 5-bit field shifted left by three, with zeros below it.
- R5: Bit 15 of each 16-bit code (the intensity flag) has no effect on the pixel output.
- R6: The pixel output is registered. It shows the entry for the index presented at the previous rising edge. Both entries of a written word are visible to a lookup sampled at the edge after the write edge.
- R7: When a lookup and a write to the same entry share a rising edge, the lookup returns the value held before that write.
- R8: Bus writes to addresses outside 0x200..0x3FF change nothing, and bus reads there return zero.
- R9: Address bits 1:0 are ignored on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Bus byte address |
| busWe | input | 1 | Bus write strobe |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Combinational readback of the addressed raw word |
| pixIdx | input | 8 | Pixel colour index |
| pixRgb | output | 24 | Registered expanded colour {red, green, blue} |

## Verification
The hardest case to reach from the ports is the collision between a bus write and a lookup of one of the entries that write is changing on the same edge. From the outside this case looks just like a one-cycle latency error.

The bench creates it deliberately. It drives the index of an odd (high-half) entry on the same edge that the write strobe rises. It samples the old colour after that edge. It then holds the index for one more edge and expects the new colour.

Separate sweeps fill every word twice, once with both intensity flags clear and once with both set. After each fill, the bench checks all 128 readback words and all 256 expanded entries against arithmetic expectations.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int ADDR_W       = 12;
  localparam int DATA_W       = 32;
  localparam int ENTRIES      = 256;
  localparam int WORDS        = ENTRIES / 2;
  localparam int CODE_W       = DATA_W / 2;
  localparam int COMP_W       = 5;
  localparam int OUT_COMP_W   = 8;
  localparam int NCOMP        = 3;
  localparam int RGB_W        = NCOMP * OUT_COMP_W;
  localparam int PIX_W        = $clog2(ENTRIES);
  localparam int WORD_IDX_W   = $clog2(WORDS);
  localparam int BYTE_LSB     = $clog2(DATA_W / 8);
  localparam int WIN_LSB      = WORD_IDX_W + BYTE_LSB;
  localparam int PAL_BASE_INT = 'h200;
  localparam int PAL_END_INT  = PAL_BASE_INT + WORDS * (DATA_W / 8);
  localparam logic [ADDR_W-1:0] PAL_BASE = PAL_BASE_INT[ADDR_W-1:0];

  typedef struct packed {
    logic                  wrEn;
    logic                  rdHit;
    logic [WORD_IDX_W-1:0] wrWord;
    logic [WORD_IDX_W-1:0] rdWord;
  } palStrobe_t;

  // Widen each 5-bit field to 8 bits; red (lowest field) lands in the top byte.
  function automatic logic [RGB_W-1:0] expandCode(input logic [CODE_W-1:0] code);
    logic [RGB_W-1:0] res;
    for (int c = 0; c < NCOMP; c++) begin
      res[(NCOMP-1-c)*OUT_COMP_W +: OUT_COMP_W] =
        {code[c*COMP_W +: COMP_W], {(OUT_COMP_W-COMP_W){1'b0}}};
    end
    return res;
  endfunction
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output palStrobe_t        strb
);
  logic inWin;
  logic [WORD_IDX_W-1:0] wordSel;

  assign inWin   = (busAddr[ADDR_W-1:WIN_LSB] == PAL_BASE[ADDR_W-1:WIN_LSB]);
  assign wordSel = busAddr[WIN_LSB-1:BYTE_LSB];

  always_comb begin
    strb.rdHit  = inWin;
    strb.rdWord = wordSel;
    strb.wrEn   = inWin & busWe;
    strb.wrWord = wordSel;
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (int'(busAddr) < PAL_BASE_INT || int'(busAddr) >= PAL_END_INT)) |-> !strb.wrEn) // R8
    else $error("write strobe outside window");

  AST_WORD_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (int'(strb.wrWord) == (int'(busAddr) - PAL_BASE_INT) / (DATA_W / 8))) // R9
    else $error("word index mismatch");
endmodule

// File: rtl/pal_dpath.sv
module pal_dpath
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  palStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PIX_W-1:0]  pixIdx,
  output logic [DATA_W-1:0] rawRd,
  output logic [RGB_W-1:0]  pixRgb
);
  logic [DATA_W-1:0] rawMem [WORDS];
  logic [RGB_W-1:0]  expMem [ENTRIES];
  logic [RGB_W-1:0]  expHalf [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign expHalf[h] = expandCode(busWdata[h*CODE_W +: CODE_W]);
  end

  assign rawRd = strb.rdHit ? rawMem[strb.rdWord] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) rawMem[i] <= '0;
      for (int i = 0; i < ENTRIES; i++) expMem[i] <= '0;
      pixRgb <= '0;
    end else begin
      pixRgb <= expMem[pixIdx];
      if (strb.wrEn) begin
        rawMem[strb.wrWord]        <= busWdata;
        expMem[{strb.wrWord, 1'b0}] <= expHalf[0];
        expMem[{strb.wrWord, 1'b1}] <= expHalf[1];
      end
    end
  end

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> rawMem[$past(strb.wrWord)] == $past(busWdata)) // R2
    else $error("raw word not stored");

  AST_PIX_GRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (pixRgb[2:0] == 3'b0) && (pixRgb[10:8] == 3'b0) && (pixRgb[18:16] == 3'b0)) // R4
    else $error("expanded colour has nonzero low bits");

  AST_PIX_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.wrEn) && $stable(pixIdx)) |=> $stable(pixRgb)) // R6
    else $error("pixel output moved without cause");
endmodule

// File: rtl/palette_ram.sv
module palette_ram
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIX_W-1:0]  pixIdx,
  output logic [RGB_W-1:0]  pixRgb
);
  palStrobe_t strb;

  pal_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  pal_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .pixIdx   (pixIdx),
    .rawRd    (busRdata),
    .pixRgb   (pixRgb)
  );
endmodule

// File: tb/tb_palette_ram.sv
`timescale 1ns/1ps
module tb_palette_ram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [128];

  always #4 clk = ~clk;

  palette_ram dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  function automatic logic [23:0] model(input logic [15:0] h);
    return {h[4:0], 3'b000, h[9:5], 3'b000, h[14:10], 3'b000};
  endfunction

  function automatic logic [23:0] modelEntry(input int e);
    logic [31:0] w;
    w = shadow[e / 2];
    return (e % 2 == 1) ? model(w[31:16]) : model(w[15:0]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic lookCheck(input string tag, input int e, input logic [23:0] exp);
    @(negedge clk);
    pixIdx = e[7:0];
    @(negedge clk);
    check(tag, {8'h0, pixRgb}, {8'h0, exp});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readCheck("R1 read word0", 12'h200, 32'h0);
    readCheck("R1 read word127", 12'h3FC, 32'h0);
    lookCheck("R1 pix 255", 255, 24'h0);
    lookCheck("R1 pix 0", 0, 24'h0);

    // Two full sweeps: intensity flags clear, then set (R5)
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 128; n++) begin
        logic [31:0] d;
        d = (n * 32'h9E3779B1) ^ (pass * 32'h5A5A1234);
        d = (pass == 0) ? (d & 32'h7FFF7FFF) : (d | 32'h80008000);
        shadow[n] = d;
        busWrite(12'h200 + 12'(n * 4), d);
      end
      for (int n = 0; n < 128; n++)
        readCheck(pass == 0 ? "R2 readback" : "R2 R5 readback", 12'h200 + 12'(n * 4), shadow[n]);
      for (int e = 0; e < 256; e++)
        lookCheck(pass == 0 ? "R3 R4 lookup" : "R3 R5 lookup", e, modelEntry(e));
    end

    // R4 field placement, R5 intensity ignored
    busWrite(12'h200, 32'h03E0_001F);
    lookCheck("R4 red only", 0, 24'hF80000);
    lookCheck("R4 green only", 1, 24'h00F800);
    busWrite(12'h204, 32'hFFFF_7C00);
    lookCheck("R4 blue only", 2, 24'h0000F8);
    lookCheck("R5 all ones", 3, 24'hF8F8F8);
    shadow[0] = 32'h03E0_001F;
    shadow[1] = 32'hFFFF_7C00;

    // R6/R7 coincident write and lookup on entry 11 (word 5, high half)
    @(negedge clk);
    pixIdx = 8'd11;
    @(negedge clk);
    begin
      logic [23:0] oldVal;
      oldVal = modelEntry(11);
      busAddr = 12'h214; busWdata = 32'h1234_5678; busWe = 1'b1;
      @(negedge clk);
      busWe = 1'b0;
      check("R7 old value on collision", {8'h0, pixRgb}, {8'h0, oldVal});
      shadow[5] = 32'h1234_5678;
      @(negedge clk);
      check("R6 new value next edge", {8'h0, pixRgb}, {8'h0, model(16'h1234)});
    end
    lookCheck("R6 low half of same word", 10, model(16'h5678));

    // R8 outside window
    busWrite(12'h1FC, 32'hDEADBEEF);
    busWrite(12'h400, 32'hCAFEF00D);
    busWrite(12'hFFC, 32'h0BADCAFE);
    readCheck("R8 word0 untouched", 12'h200, shadow[0]);
    readCheck("R8 word127 untouched", 12'h3FC, shadow[127]);
    lookCheck("R8 entry 255 untouched", 255, modelEntry(255));
    readCheck("R8 read below window", 12'h1FC, 32'h0);
    readCheck("R8 read above window", 12'h400, 32'h0);

    // R9 low address bits ignored
    busWrite(12'h20B, 32'h0421_7FE0);
    shadow[2] = 32'h0421_7FE0;
    readCheck("R9 aligned read", 12'h208, shadow[2]);
    readCheck("R9 unaligned read", 12'h20A, shadow[2]);
    lookCheck("R9 entry 4", 4, model(16'h7FE0));
    lookCheck("R9 entry 5", 5, model(16'h0421));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule